// File: doc/BRIEF.md
# PLL Channel Post-Divider

This block produces one divided clock from the clock of a parent PLL. The divide ratio comes from an 8-bit field in the channel's own control word, multiplied by a fixed extra divider chosen when the block is elaborated. The channel runs only when three conditions hold together: the disable bit in its own control word is clear, its hold bit in the control word it shares with the parent PLL and its sibling channels is clear, and the parent PLL reports lock. If any of them fails, the output is held low and the active flag drops.

A divide field of zero does not turn the channel off. It selects the largest ratio the field can express. The block is driven by the PLL clock itself. A counter reloads at the full ratio, and the ratio is sampled only at each reload, so a new divide value never cuts a period short. The control logic is a two-state machine. ST_IDLE holds the output low and takes transition IDLE_TO_RUN once the registered enable is set. ST_RUN counts and takes transition RUN_TO_IDLE once the registered enable clears. Each state also has a self-loop: IDLE_HOLD and RUN_KEEP.

Top module: `pll_chan_div`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `clk_out` and `out_active` are low.
- R2: Setting the disable bit (`chan_ctrl[8]`) makes `out_active` fall on the second rising edge after the change. `clk_out` is low from that point on.
- R3: Setting the channel's hold bit (`pll_ctrl[HOLD_POS]`, bit 4 by default) stops the channel with the same timing as R2, even while the disable bit is clear. All other `pll_ctrl` bits have no effect on the output.
- R4: Deasserting `pll_locked` stops the channel with the same timing as R2.
- R5: A divide field (`chan_ctrl[7:0]`) of zero gives the same ratio as a field of 255.
- R6: The output period N, in input cycles, equals the divide field value times `FIXED_DIV`, with `FIXED_DIV` between 1 and 8.
- R7: Each period starts with a high phase of floor(N/2) cycles, followed by the low phase. When N is 1 the output stays high while the channel is active.
- R8: Once all three enable conditions hold, `out_active` is still low after the first rising edge and is high after the second. The first high phase of `clk_out` begins in that same cycle.
- R9: A divide value written in the middle of a period takes effect at the next counter reload. The current period completes with its old ratio.
- R10: When an enable condition drops, `out_active` stays high after the first rising edge and falls after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent PLL output clock; the divider runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_locked | input | 1 | High while the parent PLL is locked and its clock is present |
| chan_ctrl | input | DIV_W+1 | Channel control word: bits [DIV_W-1:0] hold the divide field, bit DIV_W is the disable bit |
| pll_ctrl | input | PLL_W | Control word shared with the parent PLL; bit HOLD_POS is this channel's hold bit |
| clk_out | output | 1 | Divided output clock, held low when the channel is inactive |
| out_active | output | 1 | High while the channel is producing its divided clock |

## Verification
The bench builds two copies of the block side by side, both with an 8-bit divide field and hold bit 4. One copy uses `FIXED_DIV` = 1, so the divide field maps directly to the period. The other uses `FIXED_DIV` = 3, which brings a product ratio and odd totals into play. Both copies receive the same stimulus. The bench sweeps divide values 1 to 24 and also the values 0 and 255, so every high and low phase length in that range, including the divide-by-one case, is compared cycle by cycle against arithmetic expectations. Each run is stopped in turn through the disable bit, the hold bit or the lock input, so every stop path and its two-edge timing is covered. A mid-period ratio change checks that the ratio is taken only at the counter reload.

// File: rtl/pll_chan_div_pkg.sv
package pll_chan_div_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pcd_state_e;

    // Fixed-ratio limit accepted by the divider.
    localparam int PCD_FIXED_MAX = 8;

endpackage

// File: rtl/pcd_ratio.sv
module pcd_ratio #(
    parameter int DIV_W     = 8,
    parameter int FIXED_DIV = 1,
    parameter int RW        = 12
) (
    input  logic [DIV_W-1:0] div_field,
    output logic [RW-1:0]    ratio,
    output logic [RW-1:0]    high_len
);
    logic [DIV_W-1:0] div_eff;

    always_comb begin
        // zero selects the largest ratio the field can hold
        div_eff  = (div_field == '0) ? {DIV_W{1'b1}} : div_field;
        ratio    = RW'(div_eff) * RW'(FIXED_DIV);
        high_len = (ratio == RW'(1)) ? RW'(1) : (ratio >> 1);
    end
endmodule

// File: rtl/pcd_gate.sv
module pcd_gate #(
    parameter int PLL_W    = 8,
    parameter int HOLD_POS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dis_bit,
    input  logic [PLL_W-1:0] pll_ctrl,
    input  logic             pll_locked,
    output logic             run_en
);
    logic want;

    assign want = !dis_bit && !pll_ctrl[HOLD_POS] && pll_locked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_en <= 1'b0;
        else        run_en <= want;
    end
endmodule

// File: rtl/pll_chan_div.sv
module pll_chan_div
    import pll_chan_div_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int FIXED_DIV = 1,
    parameter int PLL_W     = 8,
    parameter int HOLD_POS  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pll_locked,
    input  logic [DIV_W:0]   chan_ctrl,
    input  logic [PLL_W-1:0] pll_ctrl,
    output logic             clk_out,
    output logic             out_active
);
    localparam int FIX_W = $clog2(PCD_FIXED_MAX + 1);
    localparam int RW    = DIV_W + FIX_W;

    pcd_state_e      state_q, state_d;
    logic            run_en;
    logic [RW-1:0]   ratio_new, hi_new;
    logic [RW-1:0]   cnt_q, ratio_q, hi_q;
    logic            at_reload;

    pcd_ratio #(.DIV_W(DIV_W), .FIXED_DIV(FIXED_DIV), .RW(RW)) ratio_i (
        .div_field (chan_ctrl[DIV_W-1:0]),
        .ratio     (ratio_new),
        .high_len  (hi_new)
    );

    pcd_gate #(.PLL_W(PLL_W), .HOLD_POS(HOLD_POS)) gate_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .dis_bit    (chan_ctrl[DIV_W]),
        .pll_ctrl   (pll_ctrl),
        .pll_locked (pll_locked),
        .run_en     (run_en)
    );

    assign at_reload = (cnt_q == ratio_q - RW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: IDLE_HOLD, IDLE_TO_RUN, RUN_KEEP, RUN_TO_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = run_en ? ST_RUN  : ST_IDLE;
            ST_RUN:  state_d = run_en ? ST_RUN  : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // period counter; ratio sampled only on entry and at reload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ratio_q <= RW'(1);
            hi_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (run_en) begin
                        ratio_q <= ratio_new;
                        hi_q    <= hi_new;
                    end
                end
                ST_RUN: begin
                    if (at_reload) begin
                        cnt_q   <= '0;
                        ratio_q <= ratio_new;
                        hi_q    <= hi_new;
                    end else begin
                        cnt_q <= cnt_q + RW'(1);
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        clk_out    = 1'b0;
        out_active = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                clk_out    = 1'b0;
                out_active = 1'b0;
            end
            ST_RUN: begin
                clk_out    = (cnt_q < hi_q);
                out_active = 1'b1;
            end
            default: begin
                clk_out    = 1'b0;
                out_active = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pll_chan_div_chk.sv
module pll_chan_div_chk #(
    parameter int DIV_W    = 8,
    parameter int PLL_W    = 8,
    parameter int HOLD_POS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pll_locked,
    input logic [DIV_W:0]   chan_ctrl,
    input logic [PLL_W-1:0] pll_ctrl,
    input logic             clk_out,
    input logic             out_active
);
    logic dis_w, hold_w, en_w;

    assign dis_w  = chan_ctrl[DIV_W];
    assign hold_w = pll_ctrl[HOLD_POS];
    assign en_w   = !dis_w && !hold_w && pll_locked;

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_active |-> !clk_out); // R2

    AST_DIS_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_w && $past(dis_w)) |=> !out_active); // R2

    AST_HOLD_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_w && $past(hold_w)) |=> !out_active); // R3

    AST_UNLOCK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pll_locked && $past(!pll_locked)) |=> !out_active); // R4

    AST_ACTIVE_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (en_w && $past(en_w)) |=> out_active); // R8

    AST_DROP_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_w && $past(!en_w)) |=> !out_active); // R10
endmodule

bind pll_chan_div pll_chan_div_chk #(
    .DIV_W(DIV_W), .PLL_W(PLL_W), .HOLD_POS(HOLD_POS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pll_locked (pll_locked),
    .chan_ctrl  (chan_ctrl),
    .pll_ctrl   (pll_ctrl),
    .clk_out    (clk_out),
    .out_active (out_active)
);

// File: tb/pll_chan_div_tb_top.sv
module pll_chan_div_tb_top;
    localparam int DW   = 8;
    localparam int PW   = 8;
    localparam int HP   = 4;
    localparam int FA   = 1;
    localparam int FB   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pll_locked = 1'b0;
    logic [DW:0]   chan_ctrl = {1'b1, 8'd1};
    logic [PW-1:0] pll_ctrl = '0;
    logic          clk_a, act_a, clk_b, act_b;
    int            total = 0;
    int            bad = 0;
    bit            done = 0;

    always #2 clk = ~clk;

    pll_chan_div #(.DIV_W(DW), .FIXED_DIV(FA), .PLL_W(PW), .HOLD_POS(HP)) dut_i (
        .clk(clk), .rst_n(rst_n), .pll_locked(pll_locked), .chan_ctrl(chan_ctrl),
        .pll_ctrl(pll_ctrl), .clk_out(clk_a), .out_active(act_a));

    pll_chan_div #(.DIV_W(DW), .FIXED_DIV(FB), .PLL_W(PW), .HOLD_POS(HP)) dut_b_i (
        .clk(clk), .rst_n(rst_n), .pll_locked(pll_locked), .chan_ctrl(chan_ctrl),
        .pll_ctrl(pll_ctrl), .clk_out(clk_b), .out_active(act_b));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
        end
    endtask

    function automatic int hl(input int n);
        return (n == 1) ? 1 : n / 2;
    endfunction

    function automatic logic exp_bit(input int j, input int n0, input int n1);
        int k;
        if (j < n0) return logic'(j < hl(n0));
        k = (j - n0) % n1;
        return logic'(k < hl(n1));
    endfunction

    // called at negedge; two edges to activation (R8)
    task automatic start_run(input logic [7:0] dv, input logic [PW-1:0] others);
        chan_ctrl = {1'b0, dv};
        pll_ctrl  = others & ~(PW'(1) << HP);
        pll_locked = 1'b1;
        @(negedge clk);
        chk(act_a == 1'b0 && act_b == 1'b0, "R8", "active after one edge",
            int'(act_a) + int'(act_b), 0);
        @(negedge clk);
        chk(act_a == 1'b1 && act_b == 1'b1, "R8", "active after two edges",
            int'(act_a) + int'(act_b), 2);
    endtask

    task automatic watch(input int len, input int chg_j, input logic [7:0] newdiv,
                         input int a0, input int a1, input int b0, input int b1,
                         input string req);
        int ma, mb;
        logic ea, eb, va, vb;
        ma = -1; mb = -1; va = 1'b0; vb = 1'b0;
        for (int j = 0; j < len; j++) begin
            ea = exp_bit(j, a0, a1);
            eb = exp_bit(j, b0, b1);
            if (clk_a !== ea && ma < 0) begin ma = j; va = clk_a; end
            if (clk_b !== eb && mb < 0) begin mb = j; vb = clk_b; end
            if (j == chg_j) chan_ctrl[DW-1:0] = newdiv;
            @(negedge clk);
        end
        chk(ma < 0, req, $sformatf("fixed1 wave N=%0d sample %0d", a0, ma),
            int'(va), int'(exp_bit(ma, a0, a1)));
        chk(mb < 0, req, $sformatf("fixed3 wave N=%0d sample %0d", b0, mb),
            int'(vb), int'(exp_bit(mb, b0, b1)));
    endtask

    // kind 0: disable bit (R2), 1: hold bit (R3), 2: lock loss (R4)
    task automatic stop_run(input int kind);
        string rq;
        int hi_cnt;
        rq = (kind == 0) ? "R2" : (kind == 1) ? "R3" : "R4";
        if (kind == 0) chan_ctrl[DW] = 1'b1;
        else if (kind == 1) pll_ctrl[HP] = 1'b1;
        else pll_locked = 1'b0;
        @(negedge clk);
        chk(act_a && act_b, "R10", "active one edge after stop",
            int'(act_a) + int'(act_b), 2);
        @(negedge clk);
        chk(!act_a && !act_b && !clk_a && !clk_b, rq, "stopped two edges after cause",
            int'(act_a) + int'(act_b) + int'(clk_a) + int'(clk_b), 0);
        hi_cnt = 0;
        for (int i = 0; i < 8; i++) begin
            hi_cnt += int'(clk_a) + int'(clk_b) + int'(act_a) + int'(act_b);
            @(negedge clk);
        end
        chk(hi_cnt == 0, rq, "output quiet while stopped", hi_cnt, 0);
        chan_ctrl[DW] = 1'b1;
        pll_ctrl = '0;
        pll_locked = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int na, nb, kind;
        logic [7:0] dv;
        repeat (3) @(negedge clk);
        chk(!clk_a && !act_a && !clk_b && !act_b, "R1", "outputs in reset",
            int'(clk_a) + int'(act_a), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!clk_a && !act_a && !clk_b && !act_b, "R1", "outputs after reset",
            int'(clk_a) + int'(act_a), 0);
        pll_locked = 1'b1;
        @(negedge clk);

        kind = 0;
        for (int i = 0; i < 26; i++) begin
            dv = (i < 24) ? 8'(i + 1) : ((i == 24) ? 8'd0 : 8'd255);
            na = ((dv == 0) ? 255 : int'(dv)) * FA;
            nb = ((dv == 0) ? 255 : int'(dv)) * FB;
            start_run(dv, '0);
            // R6 R7 period and phase; R5 when dv is zero
            watch(2 * nb + 3, -1, dv, na, na, nb, nb, (dv == 0) ? "R5" : "R6/R7");
            stop_run(kind);
            kind = (kind + 1) % 3;
        end

        // R3: unrelated shared-word bits ignored
        start_run(8'd5, '1);
        watch(40, -1, 8'd5, 5, 5, 15, 15, "R3");
        stop_run(1);

        // R9: change in mid-period applies at reload
        start_run(8'd4, '0);
        watch(60, 1, 8'd6, 4, 6, 12, 18, "R9");
        stop_run(0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule